// File: doc/BRIEF.md
# Receive Character Recognizer

This block watches the received byte stream of one serial channel and compares each byte against three programmable match characters. Each character slot has its own mode: it can be off, raise an interrupt only, act as the Xoff or Xon character of in-band flow control, or act as the station address in a multi-drop network. A match sets a sticky per-slot bit in a match status vector and a single summary flag in the interrupt status. These bits stay set until software clears them by writing ones.

Bytes that are not consumed by the recognizer are passed on to the receive FIFO write port one cycle later. Xoff and Xon characters are consumed. In multi-drop operation, address-flagged bytes are consumed, and data bytes pass only while this station is addressed. The transmit-pause flag tells the transmitter to hold off. The receive-enable flag shows whether data bytes are currently accepted.

Configuration uses a small write port. Slot i holds its character at address i and its mode at address 3+i. Address 6 clears match status bits (write one to clear). Address 7 clears the summary flag through bit 0.

Top module: `rx_char_recog`

## Requirements
- R1: After reset, every match status bit, the summary flag, irq, tx_pause and fifo_we are 0, and rx_enable is 1.
- R2: A mode write takes cfg_wdata[2:0] as the action code: 0 off, 1 interrupt only, 2 Xoff, 3 Xon, 4 address, and any other value is off. Every valid byte is compared with each slot whose action is not off. A match sets match_status[i] in the cycle after the byte. A slot that is off never matches.
- R3: Any match sets char_int_flag in the cycle after the byte. The flag is cleared by writing 1 to bit 0 at address 7.
- R4: Status bits are sticky. Writing 1 to bit i at address 6 clears bit i, and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the bit set.
- R5: If several slots match one byte, all their bits are set. irq is the OR of the status bits whose slot has its interrupt enable set (cfg_wdata[3] of the mode write).
- R6: A match on an Xoff slot sets tx_pause. A match on an Xon slot clears it. If both match the same byte, tx_pause is set.
- R7: Bytes matching an Xoff or Xon slot are not forwarded. Every other accepted byte appears on fifo_data with fifo_we exactly one cycle after its valid cycle, in order.
- R8: While any slot is in address mode, an address slot matches only a byte with rx_addr_flag = 1. An address-flagged byte that matches an address slot sets rx_enable, and one that does not match clears it. Address-flagged bytes are never forwarded, and data bytes are forwarded only while rx_enable is 1. rx_enable is 0 after an address slot is first configured.
- R9: While no slot is in address mode, rx_addr_flag has no effect: flagged bytes are forwarded and rx_enable is 1.
- R10: Valid bytes on consecutive cycles are each compared and forwarded, with no gap required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_addr_flag | input | 1 | Byte is an address byte (multi-drop) |
| match_status | output | 3 | Sticky per-slot match bits |
| char_int_flag | output | 1 | Sticky summary flag for any match |
| irq | output | 1 | Interrupt request |
| tx_pause | output | 1 | Transmitter hold-off from Xoff/Xon |
| rx_enable | output | 1 | Data bytes currently accepted |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Receive FIFO write data |

## Verification
A wrong compare register or mode code shows one cycle after the byte. It appears as a missing or extra match status bit and as a byte that is dropped or forwarded when it should not be. The scoreboard detects the forwarding error as soon as fifo_we fires or fails to fire. A corrupted flow-control or address-enable state does not show on the next byte. It shows on the first later byte whose forwarding depends on it, or directly on tx_pause and rx_enable. The bench therefore checks those flags after every byte that changes them.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_IRQ  = 3'd1,
        MODE_XOFF = 3'd2,
        MODE_XON  = 3'd3,
        MODE_ADDR = 3'd4
    } mode_e;

    localparam int IEN_BIT = 3;
endpackage

// File: rtl/rcr_match_unit.sv
module rcr_match_unit
    import rcr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CHARS = 3,
    parameter int ADDR_W    = 3,
    parameter int IDX       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_addr_flag,
    output logic              hit_o,
    output mode_e             mode_o,
    output logic              ien_o
);
    localparam logic [ADDR_W-1:0] CHAR_ADDR = ADDR_W'(IDX);
    localparam logic [ADDR_W-1:0] MODE_ADDR_SEL = ADDR_W'(NUM_CHARS + IDX);

    typedef struct packed {
        logic [DATA_W-1:0] ch;
        mode_e             mode;
        logic              ien;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (cfg_we && cfg_addr == CHAR_ADDR) begin
            slot_d.ch = cfg_wdata;
        end
        if (cfg_we && cfg_addr == MODE_ADDR_SEL) begin
            slot_d.ien = cfg_wdata[IEN_BIT];
            case (cfg_wdata[2:0])
                3'd1:    slot_d.mode = MODE_IRQ;
                3'd2:    slot_d.mode = MODE_XOFF;
                3'd3:    slot_d.mode = MODE_XON;
                3'd4:    slot_d.mode = MODE_ADDR;
                default: slot_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{ch: '0, mode: MODE_OFF, ien: 1'b0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign hit_o  = rx_valid && (slot_q.mode != MODE_OFF) && (rx_data == slot_q.ch)
                    && ((slot_q.mode != MODE_ADDR) || rx_addr_flag);
    assign mode_o = slot_q.mode;
    assign ien_o  = slot_q.ien;

    // R2: an off slot never reports a match
    p_off_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_OFF) |-> !hit_o);
endmodule

// File: rtl/rcr_action.sv
module rcr_action
    import rcr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CHARS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic                 rx_addr_flag,
    input  logic [NUM_CHARS-1:0] hit_i,
    input  mode_e [NUM_CHARS-1:0] modes_i,
    output logic                 tx_pause_o,
    output logic                 rx_enable_o,
    output logic                 fifo_we_o,
    output logic [DATA_W-1:0]    fifo_data_o
);
    typedef struct packed {
        logic              pause;
        logic              rx_en;
        logic              fwe;
        logic [DATA_W-1:0] fdata;
    } act_t;

    act_t act_d, act_q;
    logic xoff_hit, xon_hit, addr_hit, md_active;

    always_comb begin
        xoff_hit  = 1'b0;
        xon_hit   = 1'b0;
        addr_hit  = 1'b0;
        md_active = 1'b0;
        for (int i = 0; i < NUM_CHARS; i++) begin
            if (hit_i[i] && modes_i[i] == MODE_XOFF) xoff_hit = 1'b1;
            if (hit_i[i] && modes_i[i] == MODE_XON)  xon_hit  = 1'b1;
            if (hit_i[i] && modes_i[i] == MODE_ADDR) addr_hit = 1'b1;
            if (modes_i[i] == MODE_ADDR)             md_active = 1'b1;
        end

        act_d       = act_q;
        act_d.fdata = rx_data;
        if (xoff_hit) begin
            act_d.pause = 1'b1;
        end else if (xon_hit) begin
            act_d.pause = 1'b0;
        end
        if (rx_valid && rx_addr_flag && md_active) begin
            act_d.rx_en = addr_hit;
        end
        act_d.fwe = rx_valid && !xoff_hit && !xon_hit
                    && (!md_active || (!rx_addr_flag && act_q.rx_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{pause: 1'b0, rx_en: 1'b0, fwe: 1'b0, fdata: '0};
        end else begin
            act_q <= act_d;
        end
    end

    assign tx_pause_o  = act_q.pause;
    assign rx_enable_o = !md_active || act_q.rx_en;
    assign fifo_we_o   = act_q.fwe;
    assign fifo_data_o = act_q.fdata;

    p_xoff_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_hit |=> tx_pause_o);

    p_flow_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_hit || xon_hit) |=> !fifo_we_o);

    p_addr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_addr_flag && md_active) |=> !fifo_we_o);

    p_fwd_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !xoff_hit && !xon_hit && !md_active) |=>
        (fifo_we_o && fifo_data_o == $past(rx_data)));
endmodule

// File: rtl/rx_char_recog.sv
module rx_char_recog
    import rcr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CHARS = 3,
    localparam int ADDR_W   = $clog2(2 * NUM_CHARS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 rx_valid,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic                 rx_addr_flag,
    output logic [NUM_CHARS-1:0] match_status,
    output logic                 char_int_flag,
    output logic                 irq,
    output logic                 tx_pause,
    output logic                 rx_enable,
    output logic                 fifo_we,
    output logic [DATA_W-1:0]    fifo_data
);
    localparam logic [ADDR_W-1:0] CLR_STAT_ADDR = ADDR_W'(2 * NUM_CHARS);
    localparam logic [ADDR_W-1:0] CLR_FLAG_ADDR = ADDR_W'(2 * NUM_CHARS + 1);

    logic [NUM_CHARS-1:0]  hit;
    logic [NUM_CHARS-1:0]  ien;
    mode_e [NUM_CHARS-1:0] modes;

    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_slot
        rcr_match_unit #(
            .DATA_W   (DATA_W),
            .NUM_CHARS(NUM_CHARS),
            .ADDR_W   (ADDR_W),
            .IDX      (g)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (cfg_we),
            .cfg_addr    (cfg_addr),
            .cfg_wdata   (cfg_wdata),
            .rx_valid    (rx_valid),
            .rx_data     (rx_data),
            .rx_addr_flag(rx_addr_flag),
            .hit_o       (hit[g]),
            .mode_o      (modes[g]),
            .ien_o       (ien[g])
        );
    end

    rcr_action #(
        .DATA_W   (DATA_W),
        .NUM_CHARS(NUM_CHARS)
    ) u_action (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_addr_flag(rx_addr_flag),
        .hit_i       (hit),
        .modes_i     (modes),
        .tx_pause_o  (tx_pause),
        .rx_enable_o (rx_enable),
        .fifo_we_o   (fifo_we),
        .fifo_data_o (fifo_data)
    );

    typedef struct packed {
        logic [NUM_CHARS-1:0] status;
        logic                 flag;
    } stat_t;

    stat_t st_d, st_q;
    logic [NUM_CHARS-1:0] clr_bits;
    logic                 clr_flag;

    always_comb begin
        clr_bits = (cfg_we && cfg_addr == CLR_STAT_ADDR) ? cfg_wdata[NUM_CHARS-1:0] : '0;
        clr_flag = cfg_we && (cfg_addr == CLR_FLAG_ADDR) && cfg_wdata[0];
        st_d        = st_q;
        st_d.status = (st_q.status & ~clr_bits) | hit;
        st_d.flag   = (st_q.flag & ~clr_flag) | (|hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_status  = st_q.status;
    assign char_int_flag = st_q.flag;
    assign irq           = |(st_q.status & ien);

    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_chk
        p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> match_status[g]);
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (match_status[g] && !clr_bits[g]) |=> match_status[g]);
    end

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> char_int_flag);
endmodule

// File: tb/rx_char_recog_tb.sv
module rx_char_recog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_addr_flag = 1'b0;
    logic [2:0] match_status;
    logic       char_int_flag, irq, tx_pause, rx_enable, fifo_we;
    logic [7:0] fifo_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    rx_char_recog u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_addr_flag(rx_addr_flag), .match_status(match_status),
        .char_int_flag(char_int_flag), .irq(irq), .tx_pause(tx_pause),
        .rx_enable(rx_enable), .fifo_we(fifo_we), .fifo_data(fifo_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic flag, input bit fwd);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_addr_flag = flag;
        if (fwd) exp_q.push_back(d);
        @(negedge clk);
        rx_valid = 1'b0; rx_addr_flag = 1'b0;
    endtask

    task automatic clear_all();
        cfg_write(3'd6, 8'h07);
        cfg_write(3'd7, 8'h01);
    endtask

    // scoreboard monitor: every forwarded byte must match the queue head
    always @(negedge clk) begin
        if (rst_n && fifo_we) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R7 unexpected write actual=%0h expected=none", fifo_data);
            end else begin
                check("R7 forwarded byte", {24'h0, fifo_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", {29'h0, match_status}, 0);
        check("R1 flag", {31'h0, char_int_flag}, 0);
        check("R1 irq", {31'h0, irq}, 0);
        check("R1 pause", {31'h0, tx_pause}, 0);
        check("R1 rx_enable", {31'h0, rx_enable}, 1);
        check("R1 fifo_we", {31'h0, fifo_we}, 0);

        cfg_write(3'd0, 8'h13); cfg_write(3'd1, 8'h11); cfg_write(3'd2, 8'h41);
        cfg_write(3'd3, 8'h0A); cfg_write(3'd4, 8'h03); cfg_write(3'd5, 8'h09);

        send_byte(8'h55, 1'b0, 1'b1);
        check("R2 no match", {29'h0, match_status}, 0);
        check("R5 irq idle", {31'h0, irq}, 0);

        send_byte(8'h13, 1'b0, 1'b0);
        check("R2 xoff status", {29'h0, match_status}, 3'b001);
        check("R3 flag", {31'h0, char_int_flag}, 1);
        check("R5 irq enabled", {31'h0, irq}, 1);
        check("R6 pause set", {31'h0, tx_pause}, 1);

        cfg_write(3'd6, 8'h00);
        check("R4 write zero keeps", {29'h0, match_status}, 3'b001);
        cfg_write(3'd6, 8'h01);
        check("R4 w1c", {29'h0, match_status}, 0);
        check("R5 irq cleared", {31'h0, irq}, 0);
        check("R3 flag stays", {31'h0, char_int_flag}, 1);
        cfg_write(3'd7, 8'h01);
        check("R3 flag cleared", {31'h0, char_int_flag}, 0);

        send_byte(8'h11, 1'b0, 1'b0);
        check("R2 xon status", {29'h0, match_status}, 3'b010);
        check("R5 irq not enabled", {31'h0, irq}, 0);
        check("R6 pause cleared", {31'h0, tx_pause}, 0);
        clear_all();

        // R10 back-to-back bytes
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h41; exp_q.push_back(8'h41);
        @(negedge clk); rx_data = 8'h42; exp_q.push_back(8'h42);
        @(negedge clk); rx_data = 8'h41; exp_q.push_back(8'h41);
        @(negedge clk); rx_valid = 1'b0;
        check("R10 burst status", {29'h0, match_status}, 3'b100);
        check("R10 burst irq", {31'h0, irq}, 1);
        clear_all();

        cfg_write(3'd1, 8'h41); cfg_write(3'd4, 8'h09);
        send_byte(8'h41, 1'b0, 1'b1);
        check("R5 multi match", {29'h0, match_status}, 3'b110);
        clear_all();

        // R4 set wins over same-cycle clear
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h41; exp_q.push_back(8'h41);
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 8'h07;
        @(negedge clk);
        rx_valid = 1'b0; cfg_we = 1'b0;
        check("R4 set wins", {29'h0, match_status}, 3'b110);
        clear_all();

        cfg_write(3'd4, 8'h00); cfg_write(3'd5, 8'h00);
        send_byte(8'h41, 1'b0, 1'b1);
        check("R2 off slot", {29'h0, match_status}, 0);
        check("R3 no flag", {31'h0, char_int_flag}, 0);

        cfg_write(3'd1, 8'h13); cfg_write(3'd4, 8'h03);
        send_byte(8'h13, 1'b0, 1'b0);
        check("R6 xoff beats xon", {31'h0, tx_pause}, 1);
        check("R5 both bits", {29'h0, match_status}, 3'b011);
        cfg_write(3'd1, 8'h11);
        send_byte(8'h11, 1'b0, 1'b0);
        check("R6 xon releases", {31'h0, tx_pause}, 0);
        clear_all();

        // R8 multi-drop
        cfg_write(3'd2, 8'h7A); cfg_write(3'd5, 8'h04);
        check("R8 enable off", {31'h0, rx_enable}, 0);
        send_byte(8'h20, 1'b0, 1'b0);
        send_byte(8'h7A, 1'b1, 1'b0);
        check("R8 addressed", {31'h0, rx_enable}, 1);
        check("R8 addr status", {29'h0, match_status}, 3'b100);
        clear_all();
        send_byte(8'h21, 1'b0, 1'b1);
        send_byte(8'h7A, 1'b0, 1'b1);
        check("R8 data byte no addr match", {29'h0, match_status}, 0);
        send_byte(8'h33, 1'b1, 1'b0);
        check("R8 other address", {31'h0, rx_enable}, 0);
        send_byte(8'h22, 1'b0, 1'b0);

        cfg_write(3'd5, 8'h00);
        check("R9 enable without address slot", {31'h0, rx_enable}, 1);
        send_byte(8'h77, 1'b1, 1'b1);
        check("R9 flag ignored", {31'h0, rx_enable}, 1);

        repeat (2) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule